// File: doc/BRIEF.md
# MESI cache with barrier-aware store buffer

This block is the private data cache of one processor. It holds a handful of direct-mapped lines, each in one of the four MESI states. Its store buffer is four entries deep. The processor issues loads, stores and barrier requests on a single operation port. A peer cache sends snoop messages of two kinds: a read of a line, or an invalidate of it. The block answers with data responses and invalidate acknowledgements, and it writes dirty data back to main memory.

A store to a line the cache owns, in state M or E, normally goes straight into the line. It is parked in the store buffer instead in two cases: when a barrier has marked older buffered stores that have not yet drained, or when an older store to the same address is still waiting. A store that misses, or that finds the line shared, also waits in the buffer. The oldest buffered store asks the bus for ownership. The buffer drains strictly in order, one entry per cycle, once the line of the oldest entry is owned. Loads look in the store buffer first, newest entry first, and only then in the cache.

An owned line that a peer reads drops to shared. If that line is dirty, it is written back to memory first.

Top module: `mesi_sb_cache`

## Requirements
- R1: After reset every line is invalid and the store buffer is empty. A load then returns cpu_rvalid=1 with cpu_rhit=0. cpu_stall, req_valid, wb_valid, rsp_valid and ack_valid are all 0.
- R2: A store (cpu_op=1) is written directly into the line, which becomes M, when all of these hold: the line holds the address in state M or E, no buffered entry is marked, and no buffered entry has the same address. A snoop that reads the line in the next cycle writes back the new data.
- R3: A store that hits an M or E line is queued as an unmarked entry, and the line is left untouched, while any marked entry is in the buffer.
- R4: A barrier (cpu_op=2) marks every entry then in the buffer. The buffer drains oldest first, so every marked entry reaches the cache before any later unmarked entry.
- R5: A store that misses, or that hits a shared line, is queued. Take the oldest entry whose line is not held in M or E. If no request is outstanding, the block pulses req_valid for that entry's address one cycle after the entry becomes oldest. req_inv is 1 when the line holds that address in S, and 0 (read-invalidate) otherwise. No further request follows until a fill arrives.
- R6: A fill (fill_valid) installs the line for fill_addr in state E with fill_data. Once the oldest entry's line is held in M or E, that entry is written into the line and leaves the buffer, one entry per cycle, and the line becomes M.
- R7: A load (cpu_op=0) sets cpu_rvalid one cycle later. If the buffer holds the address, the newest matching entry supplies the data. Otherwise a valid line with a matching tag does. Otherwise cpu_rhit=0.
- R8: A snoop read (snp_inv=0) of a line held in M or E makes the line S. rsp_valid and rsp_data follow two cycles after the snoop is sampled. A line in E is not written back.
- R9: When a snoop read hits an M line, wb_valid with that line's address and data comes one cycle after the snoop is sampled, before rsp_valid.
- R10: A snoop invalidate (snp_inv=1) makes a matching line invalid and pulses ack_valid two cycles after it is sampled. An M line is written back in the cycle between. An S line is dropped without a writeback.
- R11: cpu_stall is 1 while the buffer holds four entries and during any cycle with snp_valid. An operation presented while cpu_stall is 1 is ignored.
- R12: A fill that replaces an M line holding a different tag writes that line back (wb_valid, old address, old data) one cycle after the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor operation present |
| cpu_op | input | 2 | 0 load, 1 store, 2 barrier, 3 none |
| cpu_addr | input | 4 | Word address (low 2 bits select the line) |
| cpu_wdata | input | 8 | Store data |
| cpu_stall | output | 1 | Operation not accepted this cycle |
| cpu_rvalid | output | 1 | Load result valid |
| cpu_rhit | output | 1 | Load found data |
| cpu_rdata | output | 8 | Load data |
| req_valid | output | 1 | Ownership request pulse |
| req_inv | output | 1 | 1 invalidate, 0 read-invalidate |
| req_addr | output | 4 | Requested address |
| fill_valid | input | 1 | Ownership grant with line data |
| fill_addr | input | 4 | Granted address |
| fill_data | input | 8 | Granted line data |
| snp_valid | input | 1 | Peer message present |
| snp_inv | input | 1 | 1 invalidate, 0 read |
| snp_addr | input | 4 | Snooped address |
| rsp_valid | output | 1 | Data response to the peer |
| rsp_data | output | 8 | Response data |
| ack_valid | output | 1 | Invalidate acknowledgement |
| wb_valid | output | 1 | Writeback to main memory |
| wb_addr | output | 4 | Writeback address |
| wb_data | output | 8 | Writeback data |

## Verification
Stores are driven against lines in each of the four states. A peer read that follows at once reveals whether the data went directly into the line or waited: the writeback data and the presence or absence of a writeback tell a direct write from a queued one, and an M line from an E line. A barrier is set between a missing store and a store that hits an exclusive line. The type and order of the ownership requests that follow show that the marked entry drained first. Repeated stores to one address probe the newest-first forwarding. Four outstanding misses test the stall and the rejection of a fifth store. The fill that then evicts a dirty line checks the victim writeback.

// File: rtl/mesi_sb_pkg.sv
package mesi_sb_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_t;

    localparam logic [1:0] OP_LOAD  = 2'd0;
    localparam logic [1:0] OP_STORE = 2'd1;
    localparam logic [1:0] OP_BAR   = 2'd2;

endpackage

// File: rtl/mesi_sbuf.sv
module mesi_sbuf #(
    parameter int DEPTH = 4,
    parameter int AW    = 4,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic          mark_all,
    input  logic [AW-1:0] look_addr,
    output logic          full,
    output logic          any_marked,
    output logic          head_valid,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          fwd_hit,
    output logic [DW-1:0] fwd_data
);

    typedef struct packed {
        logic [DEPTH-1:0]         vld;
        logic [DEPTH-1:0]         mrk;
        logic [DEPTH-1:0][AW-1:0] adr;
        logic [DEPTH-1:0][DW-1:0] dat;
    } sb_t;

    sb_t sb_d, sb_q;

    always_comb begin
        logic placed;
        sb_d   = sb_q;
        placed = 1'b0;
        if (mark_all) sb_d.mrk = sb_q.vld;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                sb_d.vld[i] = sb_d.vld[i+1];
                sb_d.mrk[i] = sb_d.mrk[i+1];
                sb_d.adr[i] = sb_d.adr[i+1];
                sb_d.dat[i] = sb_d.dat[i+1];
            end
            sb_d.vld[DEPTH-1] = 1'b0;
            sb_d.mrk[DEPTH-1] = 1'b0;
        end
        if (push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!placed && !sb_d.vld[i]) begin
                    sb_d.vld[i] = 1'b1;
                    sb_d.mrk[i] = 1'b0;
                    sb_d.adr[i] = push_addr;
                    sb_d.dat[i] = push_data;
                    placed      = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sb_q <= '0;
        else        sb_q <= sb_d;
    end

    // newest matching entry wins: higher slots are younger
    always_comb begin
        fwd_hit  = 1'b0;
        fwd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sb_q.vld[i] && sb_q.adr[i] == look_addr) begin
                fwd_hit  = 1'b1;
                fwd_data = sb_q.dat[i];
            end
        end
    end

    assign full       = &sb_q.vld;
    assign any_marked = |sb_q.mrk;
    assign head_valid = sb_q.vld[0];
    assign head_addr  = sb_q.adr[0];
    assign head_data  = sb_q.dat[0];

    // R11: the controller never pushes into a full buffer
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

endmodule

// File: rtl/mesi_lines.sv
module mesi_lines
    import mesi_sb_pkg::*;
#(
    parameter int NL = 4,
    parameter int TW = 2,
    parameter int DW = 8,
    parameter int IW = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dr_en,
    input  logic [IW-1:0]          dr_idx,
    input  logic [DW-1:0]          dr_data,
    input  logic                   st_en,
    input  logic [IW-1:0]          st_idx,
    input  logic [DW-1:0]          st_data,
    input  logic                   fl_en,
    input  logic [IW-1:0]          fl_idx,
    input  logic [TW-1:0]          fl_tag,
    input  logic [DW-1:0]          fl_data,
    input  logic                   sn_en,
    input  logic [IW-1:0]          sn_idx,
    input  mesi_t                  sn_state,
    output mesi_t [NL-1:0]         state_o,
    output logic  [NL-1:0][TW-1:0] tag_o,
    output logic  [NL-1:0][DW-1:0] data_o
);

    typedef struct packed {
        mesi_t [NL-1:0]         st;
        logic  [NL-1:0][TW-1:0] tg;
        logic  [NL-1:0][DW-1:0] dt;
    } ln_t;

    ln_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        if (dr_en) begin
            ln_d.dt[dr_idx] = dr_data;
            ln_d.st[dr_idx] = ST_M;
        end
        if (st_en) begin
            ln_d.dt[st_idx] = st_data;
            ln_d.st[st_idx] = ST_M;
        end
        if (fl_en) begin
            ln_d.dt[fl_idx] = fl_data;
            ln_d.tg[fl_idx] = fl_tag;
            ln_d.st[fl_idx] = ST_E;
        end
        if (sn_en) ln_d.st[sn_idx] = sn_state;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    assign state_o = ln_q.st;
    assign tag_o   = ln_q.tg;
    assign data_o  = ln_q.dt;

endmodule

// File: rtl/mesi_sb_cache.sv
module mesi_sb_cache
    import mesi_sb_pkg::*;
#(
    parameter int AW       = 4,
    parameter int DW       = 8,
    parameter int NL       = 4,
    parameter int SB_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_valid,
    input  logic [1:0]    cpu_op,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_stall,
    output logic          cpu_rvalid,
    output logic          cpu_rhit,
    output logic [DW-1:0] cpu_rdata,
    output logic          req_valid,
    output logic          req_inv,
    output logic [AW-1:0] req_addr,
    input  logic          fill_valid,
    input  logic [AW-1:0] fill_addr,
    input  logic [DW-1:0] fill_data,
    input  logic          snp_valid,
    input  logic          snp_inv,
    input  logic [AW-1:0] snp_addr,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          ack_valid,
    output logic          wb_valid,
    output logic [AW-1:0] wb_addr,
    output logic [DW-1:0] wb_data
);

    localparam int IW = $clog2(NL);
    localparam int TW = AW - IW;

    typedef struct packed {
        logic          outst;
        logic          req_v;
        logic          req_i;
        logic [AW-1:0] req_a;
        logic          wb_v;
        logic [AW-1:0] wb_a;
        logic [DW-1:0] wb_d;
        logic          p_rsp;
        logic          p_ack;
        logic [DW-1:0] p_dat;
        logic          rsp_v;
        logic [DW-1:0] rsp_d;
        logic          ack_v;
        logic          ld_v;
        logic          ld_h;
        logic [DW-1:0] ld_d;
    } ctl_t;

    ctl_t c_d, c_q;

    mesi_t [NL-1:0]         st_a;
    logic  [NL-1:0][TW-1:0] tg_a;
    logic  [NL-1:0][DW-1:0] dt_a;

    logic          sb_full, sb_marked, sb_hv, sb_fwd;
    logic [AW-1:0] sb_ha;
    logic [DW-1:0] sb_hd, sb_fd;

    logic          acc, is_ld, is_st, is_bar, direct, push, drain, need_req;
    logic          sn_en;
    mesi_t         sn_state;
    logic [IW-1:0] cidx, hidx, sidx, fidx;
    logic [TW-1:0] ctag, htag, stag, ftag;
    logic          c_own, h_match, h_own, s_hit, s_own;

    always_comb begin
        cidx = cpu_addr[IW-1:0];
        ctag = cpu_addr[AW-1:IW];
        hidx = sb_ha[IW-1:0];
        htag = sb_ha[AW-1:IW];
        sidx = snp_addr[IW-1:0];
        stag = snp_addr[AW-1:IW];
        fidx = fill_addr[IW-1:0];
        ftag = fill_addr[AW-1:IW];

        cpu_stall = sb_full || snp_valid;
        acc       = cpu_valid && !cpu_stall;
        is_ld     = acc && cpu_op == OP_LOAD;
        is_st     = acc && cpu_op == OP_STORE;
        is_bar    = acc && cpu_op == OP_BAR;

        c_own   = tg_a[cidx] == ctag && (st_a[cidx] == ST_M || st_a[cidx] == ST_E);
        h_match = tg_a[hidx] == htag;
        h_own   = h_match && (st_a[hidx] == ST_M || st_a[hidx] == ST_E);
        s_hit   = tg_a[sidx] == stag && st_a[sidx] != ST_I;
        s_own   = s_hit && (st_a[sidx] == ST_M || st_a[sidx] == ST_E);

        direct   = is_st && c_own && !sb_marked && !sb_fwd && !fill_valid;
        push     = is_st && !direct;
        drain    = sb_hv && h_own && !snp_valid && !fill_valid;
        need_req = sb_hv && !h_own && !c_q.outst && !fill_valid;

        sn_en    = snp_valid && (snp_inv ? s_hit : s_own);
        sn_state = snp_inv ? ST_I : ST_S;
    end

    always_comb begin
        c_d       = c_q;
        c_d.req_v = need_req;
        c_d.req_i = h_match && st_a[hidx] == ST_S;
        c_d.req_a = sb_ha;
        c_d.outst = (c_q.outst || need_req) && !fill_valid;

        c_d.wb_v = 1'b0;
        if (snp_valid && s_hit && st_a[sidx] == ST_M) begin
            c_d.wb_v = 1'b1;
            c_d.wb_a = snp_addr;
            c_d.wb_d = dt_a[sidx];
        end else if (fill_valid && st_a[fidx] == ST_M && tg_a[fidx] != ftag) begin
            c_d.wb_v = 1'b1;
            c_d.wb_a = {tg_a[fidx], fidx};
            c_d.wb_d = dt_a[fidx];
        end

        c_d.p_rsp = snp_valid && !snp_inv && s_own;
        c_d.p_ack = snp_valid && snp_inv;
        c_d.p_dat = dt_a[sidx];
        c_d.rsp_v = c_q.p_rsp;
        c_d.rsp_d = c_q.p_dat;
        c_d.ack_v = c_q.p_ack;

        c_d.ld_v = is_ld;
        c_d.ld_h = sb_fwd || (tg_a[cidx] == ctag && st_a[cidx] != ST_I);
        c_d.ld_d = sb_fwd ? sb_fd : dt_a[cidx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    mesi_sbuf #(.DEPTH(SB_DEPTH), .AW(AW), .DW(DW)) u_sbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_addr  (cpu_addr),
        .push_data  (cpu_wdata),
        .pop        (drain),
        .mark_all   (is_bar),
        .look_addr  (cpu_addr),
        .full       (sb_full),
        .any_marked (sb_marked),
        .head_valid (sb_hv),
        .head_addr  (sb_ha),
        .head_data  (sb_hd),
        .fwd_hit    (sb_fwd),
        .fwd_data   (sb_fd)
    );

    mesi_lines #(.NL(NL), .TW(TW), .DW(DW), .IW(IW)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .dr_en    (drain),
        .dr_idx   (hidx),
        .dr_data  (sb_hd),
        .st_en    (direct),
        .st_idx   (cidx),
        .st_data  (cpu_wdata),
        .fl_en    (fill_valid),
        .fl_idx   (fidx),
        .fl_tag   (ftag),
        .fl_data  (fill_data),
        .sn_en    (sn_en),
        .sn_idx   (sidx),
        .sn_state (sn_state),
        .state_o  (st_a),
        .tag_o    (tg_a),
        .data_o   (dt_a)
    );

    assign req_valid  = c_q.req_v;
    assign req_inv    = c_q.req_i;
    assign req_addr   = c_q.req_a;
    assign wb_valid   = c_q.wb_v;
    assign wb_addr    = c_q.wb_a;
    assign wb_data    = c_q.wb_d;
    assign rsp_valid  = c_q.rsp_v;
    assign rsp_data   = c_q.rsp_d;
    assign ack_valid  = c_q.ack_v;
    assign cpu_rvalid = c_q.ld_v;
    assign cpu_rhit   = c_q.ld_h;
    assign cpu_rdata  = c_q.ld_d;

    // R9, R12: a writeback only ever follows a snoop or a fill
    a_r9_wb_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> $past(snp_valid || fill_valid));

    // R8: a data response answers a snoop read two cycles earlier
    a_r8_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(snp_valid && !snp_inv, 2));

    // R10: every invalidate is acknowledged two cycles after sampling
    a_r10_ack_after_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_inv) |=> ##1 ack_valid);

    // R5: requests never come back to back
    a_r5_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R11: the stall is raised whenever a snoop is presented
    a_r11_stall_on_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> cpu_stall);

endmodule

// File: tb/tb_mesi_sb_cache.sv
module tb_mesi_sb_cache;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cpu_valid;
    logic [1:0] cpu_op;
    logic [3:0] cpu_addr;
    logic [7:0] cpu_wdata;
    logic       cpu_stall, cpu_rvalid, cpu_rhit;
    logic [7:0] cpu_rdata;
    logic       req_valid, req_inv;
    logic [3:0] req_addr;
    logic       fill_valid;
    logic [3:0] fill_addr;
    logic [7:0] fill_data;
    logic       snp_valid, snp_inv;
    logic [3:0] snp_addr;
    logic       rsp_valid, ack_valid, wb_valid;
    logic [7:0] rsp_data, wb_data;
    logic [3:0] wb_addr;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;

    always #4 clk = ~clk;

    mesi_sb_cache dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_stall(cpu_stall), .cpu_rvalid(cpu_rvalid), .cpu_rhit(cpu_rhit), .cpu_rdata(cpu_rdata),
        .req_valid(req_valid), .req_inv(req_inv), .req_addr(req_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_addr(snp_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ack_valid(ack_valid),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            failures = failures + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic op(input logic [1:0] o, input logic [3:0] a, input logic [7:0] d);
        cpu_valid = 1'b1; cpu_op = o; cpu_addr = a; cpu_wdata = d;
        tick();
        cpu_valid = 1'b0; cpu_op = 2'd3;
    endtask

    task automatic load_chk(input logic [3:0] a, input bit hit, input logic [7:0] d, input string req);
        op(2'd0, a, 8'h00);
        chk(cpu_rvalid === 1'b1 && cpu_rhit === hit && (!hit || cpu_rdata === d),
            req, {cpu_rhit, cpu_rdata}, {hit, d});
    endtask

    task automatic fill(input logic [3:0] a, input logic [7:0] d);
        fill_valid = 1'b1; fill_addr = a; fill_data = d;
        tick();
        fill_valid = 1'b0;
    endtask

    task automatic wait_req(input logic [3:0] a, input bit inv, input string req);
        bit seen = 1'b0;
        for (int i = 0; i < 8 && !seen; i++) begin
            tick();
            if (req_valid) seen = 1'b1;
        end
        chk(seen && req_addr === a && req_inv === inv, req, {seen, req_inv, req_addr}, {1'b1, inv, a});
    endtask

    // snoop, then check writeback one cycle on and response/ack one more cycle on
    task automatic snoop(input bit inv, input logic [3:0] a, input bit exp_wb, input logic [7:0] wbd,
                         input bit exp_rsp, input logic [7:0] rd, input string req);
        snp_valid = 1'b1; snp_inv = inv; snp_addr = a;
        #1;
        chk(cpu_stall === 1'b1, "R11 stall during snoop", cpu_stall, 1);
        tick();
        snp_valid = 1'b0;
        chk(wb_valid === exp_wb && (!exp_wb || (wb_data === wbd && wb_addr === a)) && !rsp_valid && !ack_valid,
            req, {wb_valid, wb_data}, {exp_wb, wbd});
        tick();
        chk(rsp_valid === exp_rsp && (!exp_rsp || rsp_data === rd) && ack_valid === inv && !wb_valid,
            req, {rsp_valid, ack_valid, rsp_data}, {exp_rsp, inv, rd});
    endtask

    task automatic t_reset();
        chk(!cpu_stall && !req_valid && !wb_valid && !rsp_valid && !ack_valid, "R1 outputs idle",
            {cpu_stall, req_valid, wb_valid, rsp_valid, ack_valid}, 0);
        load_chk(4'h5, 1'b0, 8'h00, "R1 load misses after reset");
    endtask

    task automatic t_miss_path();
        op(2'd1, 4'h1, 8'h11);
        wait_req(4'h1, 1'b0, "R5 read-invalidate on miss");
        load_chk(4'h1, 1'b1, 8'h11, "R7 forward from buffer");
        op(2'd1, 4'h1, 8'h12);
        load_chk(4'h1, 1'b1, 8'h12, "R7 newest entry wins");
        chk(!req_valid, "R5 no second request while outstanding", req_valid, 0);
        fill(4'h1, 8'hA0);
        tick(); tick(); tick();
        snoop(1'b0, 4'h1, 1'b1, 8'h12, 1'b1, 8'h12, "R9 M line written back before response");
        load_chk(4'h1, 1'b1, 8'h12, "R8 shared line still readable");
        op(2'd1, 4'h1, 8'h13);
        wait_req(4'h1, 1'b1, "R5 invalidate request on shared hit");
        fill(4'h1, 8'h12);
        tick(); tick();
        snoop(1'b1, 4'h1, 1'b1, 8'h13, 1'b0, 8'h00, "R10 M invalidate writes back then acks");
        load_chk(4'h1, 1'b0, 8'h00, "R10 line invalid after invalidate");
    endtask

    task automatic t_exclusive();
        fill(4'h2, 8'h22);
        load_chk(4'h2, 1'b1, 8'h22, "R6 fill installs data");
        snoop(1'b0, 4'h2, 1'b0, 8'h00, 1'b1, 8'h22, "R8 E line read: response without writeback");
        snoop(1'b1, 4'h2, 1'b0, 8'h00, 1'b0, 8'h00, "R10 S line dropped without writeback");
        load_chk(4'h2, 1'b0, 8'h00, "R10 S line now invalid");
    endtask

    task automatic t_barrier();
        fill(4'h3, 8'h30);
        op(2'd1, 4'h0, 8'h40);
        wait_req(4'h0, 1'b0, "R5 request for oldest miss");
        op(2'd2, 4'h0, 8'h00);
        op(2'd1, 4'h3, 8'h33);
        snoop(1'b0, 4'h3, 1'b0, 8'h00, 1'b1, 8'h30, "R3 store behind mark left line untouched");
        fill(4'h0, 8'h00);
        wait_req(4'h3, 1'b1, "R4 marked entry drained before later store");
        load_chk(4'h0, 1'b1, 8'h40, "R6 drained store visible in cache");
        fill(4'h3, 8'h30);
        tick(); tick();
        load_chk(4'h3, 1'b1, 8'h33, "R6 unmarked entry drained");
        op(2'd1, 4'h3, 8'h34);
        snoop(1'b0, 4'h3, 1'b1, 8'h34, 1'b1, 8'h34, "R2 direct write into owned line");
    endtask

    task automatic t_full();
        op(2'd1, 4'h4, 8'h44);
        wait_req(4'h4, 1'b0, "R5 request for eviction miss");
        op(2'd1, 4'h5, 8'h55);
        op(2'd1, 4'h6, 8'h66);
        op(2'd1, 4'h7, 8'h77);
        chk(cpu_stall === 1'b1, "R11 stall with four entries", cpu_stall, 1);
        op(2'd1, 4'h8, 8'hEE);
        fill(4'h4, 8'h00);
        chk(wb_valid === 1'b1 && wb_addr === 4'h0 && wb_data === 8'h40, "R12 victim writeback",
            {wb_valid, wb_addr, wb_data}, {1'b1, 4'h0, 8'h40});
        tick();
        chk(cpu_stall === 1'b0, "R11 stall released after drain", cpu_stall, 0);
        load_chk(4'h8, 1'b0, 8'h00, "R11 stalled store ignored");
    endtask

    initial begin
        rst_n = 1'b0; cpu_valid = 1'b0; cpu_op = 2'd3; cpu_addr = '0; cpu_wdata = '0;
        fill_valid = 1'b0; fill_addr = '0; fill_data = '0;
        snp_valid = 1'b0; snp_inv = 1'b0; snp_addr = '0;
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_miss_path();
        t_exclusive();
        t_barrier();
        t_full();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule